// File: doc/BRIEF.md
# Burst Serial Master with Shared Word Buffer

This block is a clocked serial master that moves a programmed burst of 8-bit words through a single 16-entry buffer. Software turns the block on, programs a burst length and a serial clock divisor, then selects transmit or receive together with the bit order in one control write. Data written into the buffer starts shifting at once, one word after another, while the serial clock runs.

In transmit bursts the buffer holds the outgoing words. In receive bursts software writes throwaway words, one per word it wants to receive. Each throwaway word starts one received word. The received word replaces that entry in place, so the same buffer is later read back in arrival order. A one-cycle interrupt marks the end of the burst. Between bursts software issues a pointer-clear command.

Top module: `spi_burst_master`

Register map (3-bit address):

| Address | Access | Contents |
|---|---|---|
| 0 | read/write | control: bit0 power, bit1 transmit enable, bit2 receive enable, bit3 LSB first |
| 1 | read/write | burst count, bits 3:0 |
| 2 | read/write | clock divisor, 8 bits |
| 3 | read | status: bit7 error, bit6 full, bit5 empty, bit4 busy, bits 3:0 load pointer |
| 3 | write | command: bit0 = 1 clears the pointers |
| 4 | read/write | buffer data: a write loads a word, a read takes the next word out |

## Requirements
- R1: While control bit0 (power) is 0, or while `rst` is high, all state except the control register is held in reset. Writes to the buffer have no effect, the serial clock stays low, and status reads 0x20.
- R2: Writing address 3 with bit0 = 1 zeroes the load, shift and read-back pointers and the error flag in one cycle. A shift in progress is abandoned, and status then reads 0x20.
- R3: Status (address 3) reads {error, full, empty, busy, load pointer}, from bit7 down to bits 3:0. The load pointer is the number of words loaded, modulo 16. Empty is 1 when every loaded word has been shifted.
- R4: The burst count at address 1, bits 3:0, sets the number of words in a burst, and the value 0 means 16. Full is 1 once that many words are loaded.
- R5: A buffer write while full is discarded and sets the error flag. No extra word is shifted.
- R6: With control bit1 set and bit2 clear, loaded words are shifted out on `mosi` in load order. Each word is 8 bits, sent MSB first, or LSB first when control bit3 is 1.
- R7: `sclk` idles low. `mosi` changes only while `sclk` is low, and `miso` is sampled on the rising edge. Each half period of `sclk` lasts divisor+1 system clocks.
- R8: With control bit2 set, each word written to the buffer starts the reception of one word, and `mosi` stays low throughout.
- R9: In receive bursts each received word replaces the entry that started it. Reads of address 4 return words in arrival order, and `rdata` is valid in the cycle after the read strobe.
- R10: `irq` is a one-cycle pulse, raised once when the number of shifted words reaches the burst count.
- R11: While control bits 1 and 2 are both 0, loaded words stay in the buffer and no shifting starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Burst-complete pulse |

## Verification
The assertions assume that software follows the intended sequence. The burst count is not lowered below the number of words already loaded, and configuration happens only after power is on. The count and the enables also stay unchanged while a burst is active. The stimulus keeps within these limits in every burst: it clears the pointers, programs the count, divisor and mode, writes exactly the programmed number of words, and waits for the interrupt. Only then does it perform one deliberate overfilling write. Sweeps cover all sixteen count encodings in both directions and both bit orders, with divisors 0 to 2.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  typedef enum logic [0:0] {ENG_IDLE, ENG_SHIFT} eng_state_t;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_COUNT = 3'd1;
  localparam logic [2:0] A_DIV   = 3'd2;
  localparam logic [2:0] A_STAT  = 3'd3;
  localparam logic [2:0] A_DATA  = 3'd4;

  localparam int CTRL_PWR = 0;
  localparam int CTRL_TX  = 1;
  localparam int CTRL_RX  = 2;
  localparam int CTRL_LSB = 3;
endpackage

// File: rtl/spi_burst_clkdiv.sv
module spi_burst_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
  import spi_burst_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         start,
  input  logic [W-1:0] word_in,
  input  logic         rx_mode,
  input  logic         lsb_first,
  input  logic         miso,
  output logic         sclk,
  output logic         mosi,
  output logic         busy,
  output logic         done,
  output logic         done_rx,
  output logic [W-1:0] rx_word
);
  localparam int BW = $clog2(W);

  eng_state_t    state;
  logic [BW-1:0] bit_cnt;
  logic [W-1:0]  shreg, rxreg, nxt;
  logic          lsb_q, rx_q;

  always_comb nxt = lsb_q ? (shreg >> 1) : (shreg << 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ENG_IDLE;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      done    <= 1'b0;
      bit_cnt <= '0;
      shreg   <= '0;
      rxreg   <= '0;
      lsb_q   <= 1'b0;
      rx_q    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ENG_IDLE: if (start) begin
          shreg   <= word_in;
          lsb_q   <= lsb_first;
          rx_q    <= rx_mode;
          bit_cnt <= '0;
          mosi    <= rx_mode ? 1'b0 : (lsb_first ? word_in[0] : word_in[W-1]);
          state   <= ENG_SHIFT;
        end
        ENG_SHIFT: if (tick) begin
          if (!sclk) begin
            sclk  <= 1'b1;
            rxreg <= lsb_q ? {miso, rxreg[W-1:1]} : {rxreg[W-2:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bit_cnt == BW'(W-1)) begin
              state <= ENG_IDLE;
              done  <= 1'b1;
              mosi  <= 1'b0;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
              shreg   <= nxt;
              mosi    <= rx_q ? 1'b0 : (lsb_q ? nxt[0] : nxt[W-1]);
            end
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  assign busy    = (state == ENG_SHIFT);
  assign done_rx = done && rx_q;
  assign rx_word = rxreg;

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    (state == ENG_IDLE) |-> !sclk); // R7
  AST_RX_MOSI_LOW: assert property (@(posedge clk) disable iff (rst)
    (state == ENG_SHIFT && rx_q) |-> !mosi); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
endmodule

// File: rtl/spi_burst_buf.sv
module spi_burst_buf #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  input  logic          adv,
  input  logic          adv_rx,
  input  logic [W-1:0]  rx_data,
  input  logic [AW-1:0] blen_enc,
  output logic [W-1:0]  cur_word,
  output logic [W-1:0]  rd_word,
  output logic          pending,
  output logic          full,
  output logic          empty,
  output logic          err,
  output logic          irq,
  output logic [AW-1:0] ld_ptr
);
  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] wr_cnt, sh_cnt, blen;
  logic [AW-1:0] rd_ptr;

  assign blen = (blen_enc == '0) ? CW'(DEPTH) : {1'b0, blen_enc};

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_cnt[AW-1:0]] <= push_data;
    if (adv_rx)        mem[sh_cnt[AW-1:0]] <= rx_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_cnt <= '0;
      sh_cnt <= '0;
      rd_ptr <= '0;
      err    <= 1'b0;
      irq    <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (push) begin
        if (full) err <= 1'b1;
        else      wr_cnt <= wr_cnt + 1'b1;
      end
      if (adv) begin
        sh_cnt <= sh_cnt + 1'b1;
        irq    <= ((sh_cnt + CW'(1)) == blen);
      end
      if (pop) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  assign full     = (wr_cnt == blen);
  assign empty    = (sh_cnt == wr_cnt);
  assign pending  = (sh_cnt < wr_cnt);
  assign cur_word = mem[sh_cnt[AW-1:0]];
  assign rd_word  = mem[rd_ptr];
  assign ld_ptr   = wr_cnt[AW-1:0];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    wr_cnt <= blen); // R5
  AST_SHIFT_BEHIND: assert property (@(posedge clk) disable iff (rst)
    sh_cnt <= wr_cnt); // R6
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr |=> (wr_cnt == '0 && sh_cnt == '0 && rd_ptr == '0 && !err)); // R2
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R10
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spi_burst_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  parameter int DIV_W = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         sclk,
  output logic         mosi,
  input  logic         miso,
  output logic         irq
);
  logic [3:0]       ctrl_q;
  logic [AW-1:0]    cnt_q;
  logic [DIV_W-1:0] div_q;
  logic             core_rst, clr, push, pop, en, start;
  logic             tick, busy, done, done_rx, pending, full, empty, err;
  logic [W-1:0]     cur_word, rd_word, rx_word, status;
  logic [AW-1:0]    ld_ptr;

  assign core_rst = rst || !ctrl_q[CTRL_PWR];
  assign clr      = wr_en && addr == A_STAT && wdata[0];
  assign push     = wr_en && addr == A_DATA;
  assign pop      = rd_en && addr == A_DATA;
  assign en       = ctrl_q[CTRL_TX] || ctrl_q[CTRL_RX];
  assign start    = en && pending && !busy && !done;
  assign status   = W'({err, full, empty, busy, ld_ptr});

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (wr_en && addr == A_CTRL) ctrl_q <= wdata[3:0];
  end

  always_ff @(posedge clk) begin
    if (core_rst) begin
      cnt_q <= '0;
      div_q <= '0;
    end else if (wr_en) begin
      if (addr == A_COUNT) cnt_q <= wdata[AW-1:0];
      if (addr == A_DIV)   div_q <= wdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        A_CTRL:  rdata <= W'(ctrl_q);
        A_COUNT: rdata <= W'(cnt_q);
        A_DIV:   rdata <= W'(div_q);
        A_STAT:  rdata <= status;
        A_DATA:  rdata <= core_rst ? '0 : rd_word;
        default: rdata <= '0;
      endcase
    end
  end

  spi_burst_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(core_rst || clr), .run(busy), .div(div_q), .tick(tick)
  );

  spi_burst_engine #(.W(W)) u_eng (
    .clk(clk), .rst(core_rst || clr), .tick(tick), .start(start),
    .word_in(cur_word), .rx_mode(ctrl_q[CTRL_RX]), .lsb_first(ctrl_q[CTRL_LSB]),
    .miso(miso), .sclk(sclk), .mosi(mosi), .busy(busy), .done(done),
    .done_rx(done_rx), .rx_word(rx_word)
  );

  spi_burst_buf #(.DEPTH(DEPTH), .W(W)) u_buf (
    .clk(clk), .rst(core_rst), .clr(clr), .push(push), .push_data(wdata),
    .pop(pop), .adv(done), .adv_rx(done_rx), .rx_data(rx_word),
    .blen_enc(cnt_q), .cur_word(cur_word), .rd_word(rd_word),
    .pending(pending), .full(full), .empty(empty), .err(err), .irq(irq),
    .ld_ptr(ld_ptr)
  );

  AST_PWR_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[CTRL_PWR] && $past(!ctrl_q[CTRL_PWR])) |-> (!sclk && !irq)); // R1
  AST_IDLE_NO_START: assert property (@(posedge clk) disable iff (rst)
    (!en && !busy) |=> !busy); // R11
endmodule

// File: tb/sim_spi_burst_master.sv
module sim_spi_burst_master;
  logic       clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0, miso;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  wire  [7:0] rdata;
  wire        sclk, mosi, irq;

  always #2 clk = ~clk;

  spi_burst_master u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sclk(sclk), .mosi(mosi), .miso(miso), .irq(irq)
  );

  int errs = 0, checks = 0, cyc = 0, irq_cnt = 0;
  logic [7:0] s_src [16];
  logic [7:0] cap [16];
  int s_w = 0, s_b = 0, c_w = 0, c_b = 0, mosi_bad = 0, hi_start = 0, hi_len = 0;
  bit lsb_m = 0, rx_chk = 0;

  always @(posedge clk) begin
    cyc++;
    if (irq) irq_cnt++;
  end

  always @(posedge sclk) begin
    if (c_w < 16) cap[c_w][lsb_m ? c_b : 7 - c_b] = mosi;
    if (rx_chk && mosi) mosi_bad++;
    c_b++;
    if (c_b == 8) begin c_b = 0; c_w++; end
    hi_start = cyc;
  end

  always @(negedge sclk) begin
    hi_len = cyc - hi_start;
    s_b++;
    if (s_b == 8) begin s_b = 0; s_w++; end
  end

  always_comb miso = (s_w < 16) ? s_src[s_w][lsb_m ? s_b : 7 - s_b] : 1'b0;

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    summary();
    $finish;
  end

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic slave_reset();
    s_w = 0; s_b = 0; c_w = 0; c_b = 0; mosi_bad = 0;
    for (int i = 0; i < 16; i++) cap[i] = '0;
  endtask

  task automatic wait_irq(input int base);
    int t = 0;
    while (irq_cnt == base && t < 4000) begin @(negedge clk); t++; end
  endtask

  function automatic logic [7:0] txw(input int i, input int n);
    return 8'((i * 37 + n * 11 + 5) & 255);
  endfunction

  function automatic logic [7:0] rxw(input int i, input int n);
    return 8'((i * 53 + n * 7 + 60) & 255);
  endfunction

  task automatic run_tx(input int enc, input bit lsb, input int dv);
    int n = (enc == 0) ? 16 : enc;
    int base;
    logic [7:0] d;
    wr(3'd3, 8'h01);
    rd(3'd3, d); chk("R2 clear before tx", d, 8'h20);
    slave_reset(); lsb_m = lsb; rx_chk = 0;
    wr(3'd1, 8'(enc)); wr(3'd2, 8'(dv));
    base = irq_cnt;
    wr(3'd0, {4'b0, lsb, 3'b011});
    for (int i = 0; i < n; i++) wr(3'd4, txw(i, n));
    wait_irq(base);
    repeat (4) @(negedge clk);
    chk("R10 one irq per tx burst", irq_cnt - base, 1);
    wr(3'd4, 8'hAA);
    repeat (40 * (dv + 1)) @(negedge clk);
    rd(3'd3, d); chk("R5 R3 status after overfill", d, 8'hE0 | (n & 15));
    chk("R5 no extra word shifted", c_w, n);
    for (int i = 0; i < n; i++) chk("R6 tx word", cap[i], txw(i, n));
    chk("R7 sclk high half period", hi_len, dv + 1);
  endtask

  task automatic run_rx(input int enc, input bit lsb, input int dv);
    int n = (enc == 0) ? 16 : enc;
    int base;
    logic [7:0] d;
    wr(3'd3, 8'h01);
    for (int i = 0; i < 16; i++) s_src[i] = rxw(i, n);
    slave_reset(); lsb_m = lsb; rx_chk = 1;
    wr(3'd1, 8'(enc)); wr(3'd2, 8'(dv));
    base = irq_cnt;
    wr(3'd0, {4'b0, lsb, 3'b101});
    for (int i = 0; i < n; i++) wr(3'd4, 8'hFF);
    wait_irq(base);
    repeat (4) @(negedge clk);
    chk("R10 one irq per rx burst", irq_cnt - base, 1);
    rd(3'd3, d); chk("R3 R4 status after rx burst", d, 8'h60 | (n & 15));
    for (int i = 0; i < n; i++) begin
      rd(3'd4, d); chk("R9 rx word in arrival order", d, rxw(i, n));
    end
    chk("R8 mosi low during rx", mosi_bad, 0);
    chk("R8 one word per dummy write", s_w, n);
    wr(3'd3, 8'h01);
    rd(3'd3, d); chk("R2 clear after rx", d, 8'h20);
    rx_chk = 0;
  endtask

  initial begin
    logic [7:0] d;
    int base;
    for (int i = 0; i < 16; i++) s_src[i] = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    rd(3'd3, d); chk("R1 R3 status out of reset", d, 8'h20);
    rd(3'd0, d); chk("R1 ctrl out of reset", d, 0);
    wr(3'd4, 8'h55);
    rd(3'd3, d); chk("R1 buffer write ignored while off", d, 8'h20);
    wr(3'd0, 8'h01);
    rd(3'd3, d); chk("R1 status after power on", d, 8'h20);
    wr(3'd1, 8'h05);
    rd(3'd1, d); chk("R4 count readback", d, 5);

    wr(3'd3, 8'h01);
    slave_reset(); lsb_m = 0; rx_chk = 0;
    wr(3'd1, 8'h03); wr(3'd2, 8'h00);
    for (int i = 0; i < 3; i++) wr(3'd4, txw(i, 3));
    repeat (100) @(negedge clk);
    chk("R11 nothing shifted while disabled", c_w, 0);
    rd(3'd3, d); chk("R11 R4 full and not empty", d, 8'h43);
    base = irq_cnt;
    wr(3'd0, 8'h03);
    wait_irq(base);
    repeat (4) @(negedge clk);
    chk("R11 words sent once enabled", c_w, 3);
    for (int i = 0; i < 3; i++) chk("R6 held word", cap[i], txw(i, 3));

    for (int e = 0; e < 16; e++) run_tx(e, e[0], e % 3);
    for (int e = 0; e < 16; e++) run_rx(e, e[1], (e + 1) % 3);

    wr(3'd4, 8'h11);
    wr(3'd0, 8'h00);
    wr(3'd4, 8'h22);
    rd(3'd3, d); chk("R1 status after power off", d, 8'h20);

    summary();
    $finish;
  end
endmodule